// File: doc/BRIEF.md
# Memory Clock Suspend Controller

This block handles the clock-enable input of a two-bank synchronous graphics memory. It registers the clock-enable pin on every clock, along with whether any bank is open. When clock-enable is seen low while a bank is open, the block freezes the rest of the device. It does this by dropping an operation-advance qualifier, which holds burst counters and other sequencing state in place without aborting them. While frozen, it also blocks the command-valid output.

Entry into suspend takes effect one clock after the low clock-enable is registered. Exit takes effect one clock after the high clock-enable is registered. A low clock-enable while every bank is closed does not start a suspend. That case belongs to other power-saving logic, which is outside this block.

Top module: `clkSuspendCtrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `suspended` is 0 and `opAdvance` is 1. The registered clock-enable starts at 1 and the registered bank-open flag starts at 0.
- R2: If `ckeIn` is 0 and at least one `bankActive` bit is 1 at clock edge k, then `suspended` is still 0 after edge k and becomes 1 after edge k+1.
- R3: If `ckeIn` is 0 at edge k while every `bankActive` bit is 0 and the block is not suspended, then `suspended` stays 0 after edge k+1.
- R4: While suspended, if `ckeIn` is 1 at edge k, then `suspended` stays 1 after edge k and becomes 0 after edge k+1.
- R5: Once suspended, `suspended` stays 1 for as long as `ckeIn` is registered 0, even if every bank closes.
- R6: `opAdvance` is 1 exactly when `suspended` is 0.
- R7: `cmdValid` equals `cmdStrobe` when not suspended and is 0 in every cycle where `suspended` is 1.
- R8: Either bank on its own is enough to allow suspend entry. Bit 0 of `bankActive` is bank 0 and bit 1 is bank 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ckeIn | input | 1 | Clock-enable pin as seen by the device |
| bankActive | input | NUM_BANKS | Per-bank open flags |
| cmdStrobe | input | 1 | Decoded command strobe for this cycle |
| suspended | output | 1 | Clock suspend is in force |
| opAdvance | output | 1 | Qualifier that lets clocked operations advance |
| cmdValid | output | 1 | Command strobe passed on when not suspended |

## Verification
The bench targets the two one-clock latencies. A design that suspends on the same edge that registers the low clock-enable, or that resumes on the same edge that registers the high one, shows the wrong `suspended` value in exactly one cycle. Directed cases also drive a low clock-enable with both banks closed: a design that ignores bank state would suspend there. A third case closes all banks while already suspended: a design that re-evaluates bank state every cycle would drop out of suspend early. Random clock-enable, bank and strobe patterns then check that commands never leak through during suspend and that `opAdvance` always tracks the suspend state.

// File: rtl/sgSuspPkg.sv
package sgSuspPkg;
  // Strobes sent from the control decision to the state datapath.
  typedef struct packed {
    logic setSusp;   // enter suspend on this edge
    logic clrSusp;   // leave suspend on this edge
  } suspStrobes_t;

  // Reset value of the registered clock-enable.
  localparam logic CKE_RESET = 1'b1;
endpackage

// File: rtl/suspCtrl.sv
module suspCtrl
  import sgSuspPkg::*;
(
  input  logic         ckeQ,       // clock-enable registered at the previous edge
  input  logic         actQ,       // any bank open at the previous edge
  input  logic         suspState,  // current suspend state
  output suspStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    if (!suspState) begin
      // Entry needs a low registered clock-enable together with an open bank.
      strobes.setSusp = !ckeQ && actQ;
    end else begin
      // Exit follows a high registered clock-enable.
      strobes.clrSusp = ckeQ;
    end
  end
endmodule

// File: rtl/suspPath.sv
module suspPath
  import sgSuspPkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ckeIn,
  input  logic [NUM_BANKS-1:0] bankActive,
  input  logic                 cmdStrobe,
  input  suspStrobes_t         strobes,
  output logic                 ckeQ,
  output logic                 actQ,
  output logic                 suspState,
  output logic                 opAdvance,
  output logic                 cmdValid
);
  logic anyOpen;

  // OR-reduce the bank flags one bit at a time.
  logic [NUM_BANKS:0] orChain;
  assign orChain[0] = 1'b0;
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bankOr
    assign orChain[b+1] = orChain[b] | bankActive[b];
  end
  assign anyOpen = orChain[NUM_BANKS];

  // Input pipeline: clock-enable and bank-open state for the next edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckeQ <= CKE_RESET;
      actQ <= 1'b0;
    end else begin
      ckeQ <= ckeIn;
      actQ <= anyOpen;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                suspState <= 1'b0;
    else if (strobes.setSusp) suspState <= 1'b1;
    else if (strobes.clrSusp) suspState <= 1'b0;
  end

  assign opAdvance = !suspState;
  assign cmdValid  = cmdStrobe && !suspState;

  // R2: a low registered enable with a bank open leads to suspend one edge later
  assert_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!ckeQ && actQ && !suspState) |=> suspState);

  // R3: no bank open means no suspend entry
  assert_no_idle_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ckeQ && !actQ && !suspState) |=> !suspState);

  // R4: a high registered enable ends the suspend one edge later
  assert_exit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (suspState && ckeQ) |=> !suspState);

  // R5: suspend holds while the registered enable stays low
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (suspState && !ckeQ) |=> suspState);

  // R1: reset leaves the block not suspended
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> !suspState);
endmodule

// File: rtl/clkSuspendCtrl.sv
module clkSuspendCtrl
  import sgSuspPkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ckeIn,
  input  logic [NUM_BANKS-1:0] bankActive,
  input  logic                 cmdStrobe,
  output logic                 suspended,
  output logic                 opAdvance,
  output logic                 cmdValid
);
  suspStrobes_t strobes;
  logic ckeQ, actQ, suspState;

  suspCtrl u_ctrl (
    .ckeQ      (ckeQ),
    .actQ      (actQ),
    .suspState (suspState),
    .strobes   (strobes)
  );

  suspPath #(.NUM_BANKS(NUM_BANKS)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .ckeIn      (ckeIn),
    .bankActive (bankActive),
    .cmdStrobe  (cmdStrobe),
    .strobes    (strobes),
    .ckeQ       (ckeQ),
    .actQ       (actQ),
    .suspState  (suspState),
    .opAdvance  (opAdvance),
    .cmdValid   (cmdValid)
  );

  assign suspended = suspState;

  // R7: no command passes while suspended
  assert_cmd_block_R7: assert property (@(posedge clk) disable iff (!rstN)
    suspended |-> !cmdValid);

  // R6: the advance qualifier is low exactly while suspended
  assert_advance_R6: assert property (@(posedge clk) disable iff (!rstN)
    opAdvance != suspended);
endmodule

// File: tb/clkSuspendCtrl_bench.sv
module clkSuspendCtrl_bench;
  localparam int NUM_BANKS = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ckeIn = 1'b1;
  logic [NUM_BANKS-1:0] bankActive = '0;
  logic cmdStrobe = 1'b0;
  logic suspended, opAdvance, cmdValid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Reference state, updated from the requirements.
  bit refCkeQ = 1'b1;
  bit refActQ = 1'b0;
  bit refSusp = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  clkSuspendCtrl #(.NUM_BANKS(NUM_BANKS)) u_clkSuspendCtrl (
    .clk(clk), .rstN(rstN), .ckeIn(ckeIn), .bankActive(bankActive),
    .cmdStrobe(cmdStrobe), .suspended(suspended), .opAdvance(opAdvance),
    .cmdValid(cmdValid)
  );

  function automatic bit nextSusp(bit ck, bit act, bit s);
    if (s) return !ck;      // R4 / R5
    return !ck && act;      // R2 / R3
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: update reference with inputs present at the edge, then move to the falling edge.
  task automatic tick();
    bit ns;
    ns = nextSusp(refCkeQ, refActQ, refSusp);
    refCkeQ = ckeIn;
    refActQ = |bankActive;
    refSusp = ns;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkAll(string req);
    check(req, suspended, refSusp);
    check("R6", opAdvance, !refSusp);
    check("R7", cmdValid, cmdStrobe & !refSusp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check("R1", suspended, 1'b0);
    check("R1", opAdvance, 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", suspended, 1'b0);

    // R2: bank 0 open, enable low; latency of one clock.
    bankActive = 2'b01; ckeIn = 1'b0;
    tick();
    check("R2", suspended, 1'b0);
    tick();
    check("R2", suspended, 1'b1);
    cmdStrobe = 1'b1;
    #1 check("R7", cmdValid, 1'b0);
    check("R6", opAdvance, 1'b0);
    // R5: banks close while enable stays low.
    bankActive = 2'b00;
    tick(); tick();
    check("R5", suspended, 1'b1);
    // R4: enable high; exit one clock later.
    ckeIn = 1'b1;
    tick();
    check("R4", suspended, 1'b1);
    tick();
    check("R4", suspended, 1'b0);
    #1 check("R7", cmdValid, 1'b1);
    // R3: enable low with no bank open.
    ckeIn = 1'b0; cmdStrobe = 1'b0;
    tick(); tick(); tick();
    check("R3", suspended, 1'b0);
    check("R3", opAdvance, 1'b1);
    // R8: bank 1 alone.
    bankActive = 2'b10;
    tick(); tick();
    check("R8", suspended, 1'b1);
    ckeIn = 1'b1;
    tick(); tick();
    check("R8", suspended, 1'b0);

    // Random mix.
    for (int i = 0; i < 3000; i++) begin
      ckeIn      = ($urandom % 4) != 0;
      bankActive = NUM_BANKS'($urandom);
      cmdStrobe  = $urandom % 2;
      tick();
      checkAll(refSusp ? "R5" : "R2");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule